// File: doc/BRIEF.md
# Table-Driven SPI Configuration Sequencer

After reset, this block programs a set of board devices from a small on-chip table of 32-bit words. When `start` is pulsed, it reads the words from a single-port ROM. The reads begin at address 0 and go up one address at a time. Each word goes out as a single 32-bit write frame on an SPI bus, with this block as the bus master. The top byte of each word is a routing code. A board-side slave uses it to pick one of three targets: a clock generator or one of two converters. The lower three bytes carry the target's own write instruction and register data. Typical entries put the clock generator's words first and the converter's words after them. The block does not reorder anything; it keeps the order of the table.

Each frame is sent in SPI mode 0, most significant bit first. A programmable even divider of the system clock produces SCLK. Chip select opens half an SCLK period before the first bit and closes half a period after the last bit. Consecutive frames are separated by an idle gap on chip select. The ROM has one cycle of read latency. While a frame is shifting, the block already reads the next word into a holding register. The sequence ends at the first all-zero word, which is not sent, or after a parameterised number of words. `done` then rises and stays high until the next `start`.

Top module: `cfg_spi_loader`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk`, `spi_mosi`, `rom_en`, `busy` and `done` are 0.
- R2: A `start` pulse while not busy raises `busy` and issues the first ROM read at address 0. Later reads use addresses 1, 2, 3 and so on, one read per table word.
- R3: Every frame holds exactly 32 rising SCLK edges while `spi_cs_n` is low. The word is sent MSB first, so bits 31:24 (the target routing code) go out before bits 23:0 (the device instruction and data).
- R4: `spi_mosi` changes only while SCLK is low and is stable while SCLK is high. SCLK is low whenever chip select changes.
- R5: SCLK high and low phases each last `CLK_DIV/2` system cycles. `spi_cs_n` falls one half-period before the first rising edge and rises one half-period after the last falling edge.
- R6: Between two frames, `spi_cs_n` stays high for `2*CLK_DIV + 1` system cycles, which is more than two SCLK periods.
- R7: Words are sent in table order. Every read after the first is issued while the previous frame holds `spi_cs_n` low.
- R8: An all-zero word ends the sequence and produces no frame, even when it is the first entry.
- R9: After `MAX_WORDS` words have been read, no further read is made and the sequence ends after the last frame.
- R10: `busy` falls and `done` rises in the same cycle, one cycle after the last frame's gap ends. `done` then holds while `busy` stays low.
- R11: A `start` pulse while `busy` is high has no effect on the pins, the reads or the timing.
- R12: A `start` pulse while `done` is high clears `done` and restarts the sequence from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin the configuration sequence |
| rom_en | output | 1 | ROM read enable, one cycle per word |
| rom_addr | output | ADDR_W | ROM word address |
| rom_data | input | 32 | ROM word, valid the cycle after `rom_en` |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI serial data to the slave |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; held until next start |

## Verification
The assertions rely on a ROM that returns the addressed word exactly one cycle after `rom_en`. They also rely on `ADDR_W` being wide enough for `MAX_WORDS` addresses. The bench meets both conditions: its ROM model is a registered array read on `rom_en`, and its table is larger than `MAX_WORDS`. The `start` pulses are one cycle wide. They are driven only when the block is idle, finished, or busy well inside a frame. This keeps the restart and ignored-start properties within the situations they describe.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
  // Fixed frame shape seen by the board-side slave.
  localparam int FRAME_BITS  = 32;
  localparam int ROUTE_BITS  = 8;
  localparam int LEAD_HALVES = 1;   // CS low before first rising edge
  localparam int GAP_HALVES  = 4;   // CS high after the frame (two SCLK periods)

  // System cycles per SCLK half-period for an even divider.
  function automatic int half_cycles(input int div);
    return div / 2;
  endfunction

  // Half-period index at which chip select returns high:
  // lead, then one high and one low half per bit.
  function automatic int cs_release_half();
    return LEAD_HALVES + 2 * FRAME_BITS;
  endfunction

  // Total half-periods a frame occupies, including its trailing gap.
  function automatic int frame_halves();
    return cs_release_half() + GAP_HALVES;
  endfunction
endpackage

// File: rtl/cfgspi_tick.sv
module cfgspi_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr || !en)        cnt <= '0;
    else if (cnt == CW'(HALF-1)) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == CW'(HALF-1));

  // R5: half-periods last at least two system cycles, so ticks never touch.
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cfgspi_shifter.sv
module cfgspi_shifter
  import cfgspi_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  output logic                  ready
);
  localparam int HALF   = half_cycles(CLK_DIV);
  localparam int NHALF  = frame_halves();
  localparam int CSREL  = cs_release_half();
  localparam int BITHLF = 2 * FRAME_BITS;
  localparam int HW     = $clog2(NHALF + 1);
  localparam int EW     = $clog2(FRAME_BITS + 2);

  logic                  active;
  logic [HW-1:0]         hidx;
  logic [FRAME_BITS-1:0] sreg;
  logic                  tick;
  logic                  fall_evt;

  cfgspi_tick #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (load),
    .en   (active),
    .tick (tick)
  );

  // End of an SCLK high phase inside the bit window.
  assign fall_evt = tick && hidx[0] && (hidx < HW'(BITHLF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      hidx   <= '0;
      sreg   <= '0;
    end else if (load) begin
      active <= 1'b1;
      hidx   <= '0;
      sreg   <= word;
    end else if (active && tick) begin
      if (hidx == HW'(NHALF-1)) begin
        active <= 1'b0;
        hidx   <= '0;
      end else begin
        hidx <= hidx + 1'b1;
      end
      if (fall_evt) sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign cs_n  = !(active && (hidx < HW'(CSREL)));
  assign sclk  = active && hidx[0] && (hidx < HW'(BITHLF));
  assign mosi  = sreg[FRAME_BITS-1];
  assign ready = !active;

  // Checker-side edge counter for frame length.
  logic          sclk_d, cs_d;
  logic [EW-1:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (cs_d && !cs_n)           rise_cnt <= '0;
      else if (sclk && !sclk_d)    rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r3_frame_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == EW'(FRAME_BITS)));
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  a_r4_cs_edge_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) || $fell(cs_n)) |-> !sclk);
  a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ready);
endmodule

// File: rtl/cfgspi_ctrl.sv
module cfgspi_ctrl
  import cfgspi_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int MAX_WORDS = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  rom_en,
  output logic [ADDR_W-1:0]     rom_addr,
  input  logic [FRAME_BITS-1:0] rom_data,
  input  logic                  sh_ready,
  output logic                  load,
  output logic [FRAME_BITS-1:0] load_word,
  output logic                  busy,
  output logic                  done_o
);
  localparam int PW = $clog2(MAX_WORDS + 1);

  logic                  run, fin_q, rd_req, rd_q, hold_full, tbl_end;
  logic [FRAME_BITS-1:0] hold_word;
  logic [PW-1:0]         ptr;
  logic                  hold_zero, launch, finish;

  assign hold_zero = (hold_word == '0);
  assign launch    = run && sh_ready && hold_full && !hold_zero;
  assign finish    = run && sh_ready && (tbl_end || (hold_full && hold_zero));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      fin_q     <= 1'b0;
      rd_req    <= 1'b0;
      rd_q      <= 1'b0;
      hold_full <= 1'b0;
      tbl_end   <= 1'b0;
      hold_word <= '0;
      ptr       <= '0;
    end else begin
      rd_req <= 1'b0;
      rd_q   <= rd_req;
      if (!run) begin
        if (start) begin
          run       <= 1'b1;
          fin_q     <= 1'b0;
          ptr       <= '0;
          rd_req    <= 1'b1;
          hold_full <= 1'b0;
          tbl_end   <= 1'b0;
        end
      end else begin
        if (rd_q) begin
          hold_word <= rom_data;
          hold_full <= 1'b1;
          ptr       <= ptr + 1'b1;
        end
        if (launch) begin
          hold_full <= 1'b0;
          if (ptr == PW'(MAX_WORDS)) tbl_end <= 1'b1;
          else                       rd_req  <= 1'b1;
        end
        if (finish) begin
          run       <= 1'b0;
          fin_q     <= 1'b1;
          hold_full <= 1'b0;
        end
      end
    end
  end

  assign rom_en    = rd_req;
  assign rom_addr  = ADDR_W'(ptr);
  assign load      = launch;
  assign load_word = hold_word;
  assign busy      = run;
  assign done_o    = fin_q;

  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rom_en && rom_addr == '0));
  a_r7_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> busy);
  a_r9_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (ptr < PW'(MAX_WORDS)));
  a_r8_zero_not_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold_full && hold_zero) |-> !load);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish) |=> busy);
  a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start) |=> (busy && !done_o));
endmodule

// File: rtl/cfg_spi_loader.sv
module cfg_spi_loader
  import cfgspi_pkg::*;
#(
  parameter int CLK_DIV   = 8,
  parameter int ADDR_W    = 6,
  parameter int MAX_WORDS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [31:0]       rom_data,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              busy,
  output logic              done
);
  logic                  sh_ready;
  logic                  sh_load;
  logic [FRAME_BITS-1:0] sh_word;

  cfgspi_ctrl #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rom_en   (rom_en),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .sh_ready (sh_ready),
    .load     (sh_load),
    .load_word(sh_word),
    .busy     (busy),
    .done_o   (done)
  );

  cfgspi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sh_load),
    .word (sh_word),
    .sclk (spi_sclk),
    .cs_n (spi_cs_n),
    .mosi (spi_mosi),
    .ready(sh_ready)
  );

  // R6: a new frame opens only after the previous one has closed.
  a_r6_gap_before_open: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(sh_load));
endmodule

// File: tb/tb_cfg_spi_loader.sv
module tb_cfg_spi_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 6;
  localparam int ADDR_W     = 4;
  localparam int MAX_WORDS  = 5;
  localparam int HALF       = CLK_DIV / 2;
  localparam int ROM_DEPTH  = 16;

  typedef struct packed {
    logic cs;
    logic sc;
    logic mo;
    logic bu;
    logic dn;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rom_en;
  logic [ADDR_W-1:0] rom_addr;
  logic [31:0] rom_q = '0;
  logic spi_sclk, spi_cs_n, spi_mosi, busy, done;

  logic [31:0] rom_mem [ROM_DEPTH];

  int total = 0;
  int bad = 0;
  int edge_cnt = 0;
  int start_edge = -1;
  logic pre_done = 1'b0;
  string cur_tag = "R1";
  exp_t exp_q[$];

  logic [31:0] dec_q[$];
  int bits_q[$];
  int rd_log[$];
  int pref_cnt = 0;
  logic [31:0] dec_word = '0;
  int dec_bits = 0;
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;

  cfg_spi_loader #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_q),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    edge_cnt <= edge_cnt + 1;
    if (rom_en) rom_q <= rom_mem[rom_addr];
  end

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Per-cycle reference comparison of the pins and status.
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      int k;
      k = edge_cnt - start_edge;
      if (start_edge < 0 || k < 0) e = {1'b1, 1'b0, 1'b0, 1'b0, pre_done};
      else if (k < exp_q.size())   e = exp_q[k];
      else                         e = {1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
      total++;
      if ({spi_cs_n, spi_sclk, spi_mosi, busy, done} !== e) begin
        bad++;
        $display("FAIL %s cycle %0d cs/sclk/mosi/busy/done: actual=%b expected=%b",
                 cur_tag, k, {spi_cs_n, spi_sclk, spi_mosi, busy, done}, e);
      end
    end
  end

  // Frame decoder and ROM read monitor.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_cs_n && prev_cs) begin
        dec_word = '0;
        dec_bits = 0;
      end
      if (!spi_cs_n && spi_sclk && !prev_sclk) begin
        dec_word = {dec_word[30:0], spi_mosi};
        dec_bits++;
      end
      if (spi_cs_n && !prev_cs) begin
        dec_q.push_back(dec_word);
        bits_q.push_back(dec_bits);
      end
      prev_cs   = spi_cs_n;
      prev_sclk = spi_sclk;
      if (rom_en) begin
        rd_log.push_back(int'(rom_addr));
        if (!spi_cs_n) pref_cnt++;
      end
    end
  end

  // Expected waveform: 3 busy setup cycles, then each frame of 69 half-periods
  // followed by one busy idle cycle; done afterwards.
  task automatic build(input logic [31:0] ws[$]);
    exp_q.delete();
    repeat (3) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    foreach (ws[n]) begin
      for (int h = 0; h < 69; h++) begin
        exp_t e;
        e.cs = (h >= 65);
        e.sc = (h % 2 == 1) && (h < 64);
        e.mo = (h < 64) ? ws[n][31 - h/2] : 1'b0;
        e.bu = 1'b1;
        e.dn = 1'b0;
        repeat (HALF) exp_q.push_back(e);
      end
      exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    end
  endtask

  task automatic run_seq(input string tag, input string end_req, input int poke);
    logic [31:0] ws[$];
    int reads;
    reads = 0;
    for (int i = 0; i < MAX_WORDS; i++) begin
      reads++;
      if (rom_mem[i] == 32'h0) break;
      ws.push_back(rom_mem[i]);
    end
    dec_q.delete(); bits_q.delete(); rd_log.delete(); pref_cnt = 0;
    @(posedge clk); #1;
    pre_done   = (start_edge >= 0);
    start      = 1'b1;
    start_edge = edge_cnt + 1;
    cur_tag    = tag;
    build(ws);
    @(posedge clk); #1 start = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(posedge clk);
      #1 start = 1'b1;          // R11: start while busy
      @(posedge clk); #1 start = 1'b0;
    end
    while (edge_cnt - start_edge < exp_q.size() + 20) @(posedge clk);
    #1;
    chk(end_req, "frame count", dec_q.size(), ws.size());
    for (int i = 0; i < ws.size() && i < dec_q.size(); i++) begin
      chk("R3", "bits in frame", bits_q[i], 32);
      chk("R3", "route code bits 31:24", dec_q[i][31:24], ws[i][31:24]);
      chk("R7", "word in table order", dec_q[i], ws[i]);
    end
    chk("R9", "number of ROM reads", rd_log.size(), reads);
    for (int i = 0; i < rd_log.size(); i++) chk("R2", "read address", rd_log[i], i);
    chk("R7", "reads issued during a frame", pref_cnt, reads - 1);
    chk("R10", "done held at end", done, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROM_DEPTH; i++) rom_mem[i] = 32'hFFFF_FFFF;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cs_n after reset", spi_cs_n, 1);
    chk("R1", "sclk after reset", spi_sclk, 0);
    chk("R1", "mosi after reset", spi_mosi, 0);
    chk("R1", "rom_en after reset", rom_en, 0);
    chk("R1", "busy/done after reset", {busy, done}, 0);
    repeat (10) @(posedge clk);

    // Zero entry terminates after three words.
    rom_mem[0] = 32'h8100_6E01;
    rom_mem[1] = 32'h82AA_5501;
    rom_mem[2] = 32'h84C3_F00F;
    rom_mem[3] = 32'h0;
    run_seq("R3/R4/R5/R6/R8/R10", "R8", 0);

    // Restart from done; table longer than the count limit; start poked mid-frame.
    for (int i = 0; i < ROM_DEPTH; i++) rom_mem[i] = 32'h1357_9BDF ^ (i * 32'h0101_0111);
    run_seq("R4/R5/R6/R9/R11/R12", "R9", 300);

    // First entry zero: no frame at all.
    rom_mem[0] = 32'h0;
    run_seq("R8/R10/R12", "R8", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule